// File: doc/BRIEF.md
# Cascadable Serial Configuration Bitstream Memory

This block models a one-bit-wide configuration memory that an FPGA in master serial mode reads to load its bitstream. Each rising clock edge moves an internal address counter forward by one, and the bit it selects appears on the data output. Contents come from a parameter. Bit 0 is read first, and bit `k` is `INIT[k]`.

Devices can be chained. When a device has shifted out its last bit, it stops driving its data line and pulls its cascade output low. That output feeds the chip enable of the next device, so the next device starts driving its own bit 0 on the following clock, with no gap in the stream. A combined reset/output-enable input has an active level chosen by a stored bit (`RST_ACTIVE_HIGH`). At that level it clears the address and re-arms the device, so an aborted configuration starts again from the beginning. After power good is asserted, the device runs a power-on cycle of `POR_CYCLES` clocks. During that cycle it pulls its open-drain ready indicator low.

Top module: `cfg_bitstream_mem`

## Requirements
- R1: After `por_n` rises, `ready_low_drv` is 1 (pulling the line low) for exactly `POR_CYCLES` rising clock edges and is 0 afterwards. While it is 1, `data_oe` is 0 and `ceo_n` is 1.
- R2: While `ce_n`=0, `ser_en`=1, reset/output-enable is inactive and the device is not exhausted, `data_oe` is 1 and `data_o` equals `INIT[addr]`. The address starts at 0 and advances by one per rising edge.
- R3: The rising edge that consumes bit `DEPTH-1` drives `ceo_n` low and `data_oe` low together. In a two-device chain, the downstream device presents its bit 0 in the very next cycle, so the serial stream is the first device's contents followed by the second's. At most one device drives at a time.
- R4: While `ce_n`=1, `data_oe` is 0 and the address holds. Reading continues from the next unread bit when `ce_n` returns low.
- R5: While `ser_en`=0, `data_oe` is 0 and the address holds.
- R6: When `rst_oe` equals `RST_ACTIVE_HIGH` (the active level), `data_oe` is 0 at once. The next edge clears the address to 0 and returns `ceo_n` high, for either polarity setting.
- R7: An exhausted device keeps `ceo_n` low and `data_oe` low on further clocks for as long as `rst_oe` stays at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial configuration clock; the address advances on the rising edge |
| por_n | input | 1 | Asynchronous active-low power-good; low holds the device in power-on reset |
| ce_n | input | 1 | Active-low chip enable |
| rst_oe | input | 1 | Combined reset/output-enable; its active level is set by `RST_ACTIVE_HIGH` |
| ser_en | input | 1 | Serial enable; must be high for reads |
| data_o | output | 1 | Serial bitstream data; 0 when not driven |
| data_oe | output | 1 | Tri-state enable for `data_o` |
| ceo_n | output | 1 | Active-low cascade enable to the next device |
| ready_low_drv | output | 1 | 1 while the open-drain ready line is pulled low |

## Verification
If the address counter is wrong, the error shows on the very next sampled bit: every later bit of the concatenated stream moves or mismatches. If the exhausted flag is wrong, the error shows in the cycle of the boundary, as two drivers at once, a missing bit or a repeated bit. Reset and pause faults show within one cycle of the stimulus, either as a stream that fails to restart at bit 0 or as a stream that skips bits when it resumes. Both reset polarities are run side by side on identical chains, so an inverted level decode leaves one of the two chains visibly out of step.

// File: rtl/cfg_bitstream_mem.sv
module cfg_bitstream_mem #(
  parameter int unsigned        DEPTH           = 64,
  parameter int unsigned        POR_CYCLES      = 8,
  parameter bit                 RST_ACTIVE_HIGH = 1'b1,
  parameter logic [DEPTH-1:0]   INIT            = '0
) (
  input  logic clk,
  input  logic por_n,
  input  logic ce_n,
  input  logic rst_oe,
  input  logic ser_en,
  output logic data_o,
  output logic data_oe,
  output logic ceo_n,
  output logic ready_low_drv
);
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int PW = $clog2(POR_CYCLES + 1) + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [PW-1:0] por_cnt;
  logic [AW-1:0] addr;
  logic          done;
  logic          por_busy, rst_act, run;

  assign por_busy = (por_cnt != PW'(POR_CYCLES));
  assign rst_act  = (rst_oe == RST_ACTIVE_HIGH);
  assign run      = !ce_n && ser_en && !rst_act && !por_busy && !done;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)        por_cnt <= '0;
    else if (por_busy) por_cnt <= por_cnt + 1'b1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      addr <= '0;
      done <= 1'b0;
    end else if (por_busy || rst_act) begin
      addr <= '0;
      done <= 1'b0;
    end else if (run) begin
      if (addr == LAST) done <= 1'b1;
      else              addr <= addr + 1'b1;
    end

  assign data_oe       = run;
  assign data_o        = run & INIT[addr];
  assign ceo_n         = !done;
  assign ready_low_drv = por_busy;

  AST_POR_QUIET: assert property (@(posedge clk) disable iff (!por_n)
    ready_low_drv |-> (!data_oe && ceo_n));                              // R1
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!por_n)
    data_oe |=> (!ceo_n || addr == $past(addr) + 1'b1));                 // R2
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!por_n)
    !ceo_n |-> !data_oe);                                                // R3
  AST_CE_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (ce_n && !rst_act && !ready_low_drv) |=> $stable(addr));             // R4
  AST_SER_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (!ser_en && !rst_act && !ready_low_drv) |=> $stable(addr));          // R5
  AST_RST_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
    rst_act |=> (addr == '0 && ceo_n));                                  // R6
  AST_EXHAUST_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (!ceo_n && !rst_act) |=> !ceo_n);                                    // R7
endmodule

// File: tb/cfg_bitstream_mem_tb.sv
module cfg_bitstream_mem_tb;
  localparam int unsigned D = 64;
  localparam int unsigned P = 8;
  localparam logic [D-1:0] IMG0 = 64'hA5C3_0FF0_1234_9ABC;
  localparam logic [D-1:0] IMG1 = 64'h5E17_C0DE_8001_F00D;

  logic clk = 0, por_n = 0, ce_n = 1, rst_req = 0, ser_en = 1;
  logic d_a, oe_a, ceo_a, rdy_a, d_b, oe_b, ceo_b, rdy_b;
  logic d_c, oe_c, ceo_c, rdy_c, d_d, oe_d, ceo_d, rdy_d;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  cfg_bitstream_mem #(.DEPTH(D), .POR_CYCLES(P), .RST_ACTIVE_HIGH(1'b1), .INIT(IMG0)) u_dut (
    .clk(clk), .por_n(por_n), .ce_n(ce_n), .rst_oe(rst_req), .ser_en(ser_en),
    .data_o(d_a), .data_oe(oe_a), .ceo_n(ceo_a), .ready_low_drv(rdy_a));
  cfg_bitstream_mem #(.DEPTH(D), .POR_CYCLES(P), .RST_ACTIVE_HIGH(1'b1), .INIT(IMG1)) u_dut_b (
    .clk(clk), .por_n(por_n), .ce_n(ceo_a), .rst_oe(rst_req), .ser_en(ser_en),
    .data_o(d_b), .data_oe(oe_b), .ceo_n(ceo_b), .ready_low_drv(rdy_b));
  cfg_bitstream_mem #(.DEPTH(D), .POR_CYCLES(P), .RST_ACTIVE_HIGH(1'b0), .INIT(IMG0)) u_dut_c (
    .clk(clk), .por_n(por_n), .ce_n(ce_n), .rst_oe(!rst_req), .ser_en(ser_en),
    .data_o(d_c), .data_oe(oe_c), .ceo_n(ceo_c), .ready_low_drv(rdy_c));
  cfg_bitstream_mem #(.DEPTH(D), .POR_CYCLES(P), .RST_ACTIVE_HIGH(1'b0), .INIT(IMG1)) u_dut_d (
    .clk(clk), .por_n(por_n), .ce_n(ceo_c), .rst_oe(!rst_req), .ser_en(ser_en),
    .data_o(d_d), .data_oe(oe_d), .ceo_n(ceo_d), .ready_low_drv(rdy_d));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_bit(input int k);
    return (k < int'(D)) ? IMG0[k] : IMG1[k - int'(D)];
  endfunction

  // sample both chains at the current negedge against stream bit k
  task automatic chk_bit(input int k, input string req);
    chk((d_a | d_b) == exp_bit(k), {req, " high-pol bit"}, int'(d_a | d_b), int'(exp_bit(k)));
    chk((d_c | d_d) == exp_bit(k), {req, " low-pol bit"}, int'(d_c | d_d), int'(exp_bit(k)));
    chk((oe_a ^ oe_b) && (oe_c ^ oe_d), "R3 single driver", int'({oe_a, oe_b, oe_c, oe_d}), 0);
  endtask

  task automatic read_bits(input int from, input int to, input string req);
    for (int k = from; k <= to; k++) begin
      @(negedge clk);
      chk_bit(k, req);
    end
  endtask

  task automatic t_power;
    por_n = 0; ce_n = 1; rst_req = 0; ser_en = 1;
    #9;
    @(negedge clk); por_n = 1;
    #0.5;
    chk(rdy_a && rdy_b && rdy_c && rdy_d, "R1 ready held low", int'(rdy_a), 1);
    ce_n = 0;
    repeat (P - 1) @(negedge clk);
    chk(rdy_a && !oe_a && !oe_c && ceo_a, "R1 quiet near end of por", int'(oe_a), 0);
    @(negedge clk);
    chk(!rdy_a && !rdy_b && !rdy_c && !rdy_d, "R1 ready released", int'(rdy_a), 0);
    chk(oe_a && oe_c && ceo_a && ceo_c, "R2 drive after por", int'(oe_a), 1);
    chk_bit(0, "R2");
  endtask

  task automatic t_stream;
    for (int k = 1; k < int'(2 * D); k++) begin
      @(negedge clk);
      chk_bit(k, "R2");
      if (k == int'(D)) begin
        chk(!ceo_a && !oe_a && oe_b, "R3 handoff high-pol", int'(oe_b), 1);
        chk(!ceo_c && !oe_c && oe_d, "R3 handoff low-pol", int'(oe_d), 1);
      end
    end
    repeat (4) begin
      @(negedge clk);
      chk(!oe_a && !oe_b && !oe_c && !oe_d, "R7 exhausted chain silent", int'(oe_b | oe_d), 0);
      chk(!ceo_b && !ceo_d && !ceo_a, "R7 cascade stays low", int'(ceo_b), 0);
    end
  endtask

  task automatic t_abort;
    @(posedge clk); #1 rst_req = 1;
    @(negedge clk);
    chk(!oe_a && !oe_b && !oe_c && !oe_d, "R6 output off at active level", int'(oe_b | oe_d), 0);
    @(negedge clk);
    chk(ceo_a && ceo_b && ceo_c && ceo_d, "R6 cascade re-armed", int'(ceo_a), 1);
    @(posedge clk); #1 rst_req = 0;
    read_bits(0, 9, "R6 restart");
    @(posedge clk); #1 rst_req = 1;
    @(posedge clk); #1 rst_req = 0;
    read_bits(0, 4, "R6 mid-stream abort");
  endtask

  task automatic t_pause;
    @(posedge clk); #1 ce_n = 1;
    @(negedge clk);
    chk(!oe_a && !oe_c && (d_a | d_b) == 0, "R4 no drive when disabled", int'(oe_a), 0);
    repeat (3) @(posedge clk);
    #1 ce_n = 0;
    read_bits(5, 9, "R4 resume");
    @(posedge clk); #1 ser_en = 0;
    @(negedge clk);
    chk(!oe_a && !oe_c, "R5 no drive without serial enable", int'(oe_a), 0);
    repeat (3) @(posedge clk);
    #1 ser_en = 1;
    read_bits(10, int'(2 * D) - 1, "R5 resume");
    @(negedge clk);
    chk(!oe_b && !oe_d && !ceo_b && !ceo_d, "R7 exhausted after resume", int'(oe_b), 0);
  endtask

  initial begin
    t_power();
    t_stream();
    t_abort();
    t_pause();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule